// File: doc/BRIEF.md
# Power-Fail Init Sequencer

This block decides when the processor may run after power comes up or after a supply fault. It watches two supply status lines. A high DC-low means the logic supply cannot be trusted. A high AC-low means line power is failing. From these it drives a processor init output, which holds the CPU in reset with its clock stopped, and a clock-enable output.

When DC-low has been clear for a long, fixed hold-off, init is released. The processor clock then starts and the microsequencer begins at its power-up address. If DC-low comes back at any time, init asserts again and the full hold-off starts over.

The hold-off is a parameter counted in system clock cycles. Its default matches 120 ms on a 50 MHz clock, and a simulation can shorten it. DC-low is brought into the clock domain through a synchronizer of configurable depth. AC-low is only an early warning and takes no part in the init decision.

Top module: `pwr_init_sequencer`

## Requirements
- R1: While `rstN` is low and on the first sample after it rises, `procInit` is 1 and `procClkEn` is 0.
- R2: `procClkEn` is always the inverse of `procInit` while out of reset.
- R3: `dcLow` passes through a chain of SYNC_STAGES flip-flops that reset to 1, meaning the supply is bad. A change of `dcLow` therefore acts only after SYNC_STAGES+1 rising edges.
- R4: `dcLow` may be sampled low on N consecutive rising edges, with the first of them counted as edge 1. `procInit` falls right after edge N = DELAY_CYCLES + SYNC_STAGES + 1 and not earlier.
- R5: When `dcLow` is sampled high while running, `procInit` rises right after the (SYNC_STAGES+1)th rising edge, counting the first high sample as edge 1.
- R6: A high pulse on `dcLow` as short as one cycle during the hold-off raises `procInit` if it was low. It also restarts the hold-off in full, so the release again takes the count given in R4 from the first low sample after the pulse.
- R7: `acLow` has no effect on `procInit` or `procClkEn`, whether the block is running, counting or holding.
- R8: While `dcLow` stays high, `procInit` stays 1 no matter how long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset of the sequencer |
| acLow | input | 1 | Line power unreliable when 1 (advisory only) |
| dcLow | input | 1 | Logic supply unreliable when 1 (asynchronous) |
| procInit | output | 1 | 1 holds the processor in reset with its clock stopped |
| procClkEn | output | 1 | 1 lets the processor clock run |

## Verification
The hardest case to reach is a supply glitch that lands in the middle of the hold-off. The countdown must be caught part-way and shown to restart from zero rather than resume. A directed step drops DC-low, waits part of the delay, and then pulses DC-low high for a single cycle. It then measures in edges how long the next release takes. Random phases of DC-low, many shorter than the synchronizer plus delay, revisit this case many times while AC-low toggles freely. A cycle-accurate model checks every cycle.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } seqStrobes_t;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_COUNT = 2'd1,
    ST_RUN   = 2'd2
  } seqState_t;

endpackage

// File: rtl/pwrseq_datapath.sv
module pwrseq_datapath
  import pwrseq_pkg::*;
#(
  parameter int DELAY_CYCLES = 6000000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        dcLow,
  input  seqStrobes_t strobes,
  output logic        dcBad,
  output logic        cntDone
);

  localparam int CNT_W = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       cnt;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= dcLow;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], dcLow};
      end
    end
  endgenerate

  assign dcBad = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        cnt <= '0;
    else if (strobes.cntClr)          cnt <= '0;
    else if (strobes.cntInc && !cntDone) cnt <= cnt + 1'b1;
  end

  assign cntDone = (cnt == LAST);

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= LAST);

  // R6
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntClr |=> (cnt == '0));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.cntInc && !strobes.cntClr && !cntDone) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

endmodule

// File: rtl/pwrseq_control.sv
module pwrseq_control
  import pwrseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        dcBad,
  input  logic        cntDone,
  output seqStrobes_t strobes,
  output logic        procInit,
  output logic        procClkEn
);

  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      ST_HOLD: begin
        strobes.cntClr = 1'b1;
        if (!dcBad) nextState = ST_COUNT;
      end
      ST_COUNT: begin
        strobes.cntInc = 1'b1;
        if (dcBad) begin
          strobes.cntClr = 1'b1;
          nextState      = ST_HOLD;
        end else if (cntDone) begin
          nextState = ST_RUN;
        end
      end
      ST_RUN: begin
        if (dcBad) nextState = ST_HOLD;
      end
      default: nextState = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_HOLD;
      procInit  <= 1'b1;
      procClkEn <= 1'b0;
    end else begin
      state     <= nextState;
      procInit  <= (nextState != ST_RUN);
      procClkEn <= (nextState == ST_RUN);
    end
  end

  // R2
  clk_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    procClkEn != procInit);

  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(procInit) |-> ($past(cntDone) && !$past(dcBad)));

  // R5
  reassert_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dcBad && !procInit) |=> procInit);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dcBad && procInit) |=> procInit);

endmodule

// File: rtl/pwr_init_sequencer.sv
module pwr_init_sequencer
  import pwrseq_pkg::*;
#(
  parameter int DELAY_CYCLES = 6000000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic acLow,
  input  logic dcLow,
  output logic procInit,
  output logic procClkEn
);

  seqStrobes_t strobes;
  logic        dcBad;
  logic        cntDone;
  logic        unusedAcLow;

  // AC-low is an advisory warning only (R7)
  assign unusedAcLow = acLow;

  pwrseq_datapath #(
    .DELAY_CYCLES(DELAY_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .dcLow  (dcLow),
    .strobes(strobes),
    .dcBad  (dcBad),
    .cntDone(cntDone)
  );

  pwrseq_control i_control (
    .clk      (clk),
    .rstN     (rstN),
    .dcBad    (dcBad),
    .cntDone  (cntDone),
    .strobes  (strobes),
    .procInit (procInit),
    .procClkEn(procClkEn)
  );

endmodule

// File: tb/test_pwr_init_sequencer.sv
`timescale 1ns/1ps
module test_pwr_init_sequencer;

  localparam int DLY = 20;
  localparam int SYN = 2;
  localparam int RELEASE_EDGES  = DLY + SYN + 1;
  localparam int REASSERT_EDGES = SYN + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic acLow = 1'b0;
  logic dcLow = 1'b1;
  logic procInit, procClkEn;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit monOn = 1'b0;

  always #2.5 clk = ~clk;

  pwr_init_sequencer #(.DELAY_CYCLES(DLY), .SYNC_STAGES(SYN)) i_pwr_init_sequencer (
    .clk(clk), .rstN(rstN), .acLow(acLow), .dcLow(dcLow),
    .procInit(procInit), .procClkEn(procClkEn)
  );

  // Reference built from R3/R4/R5: a delay line of SYN samples, then a run
  // length of clean samples; init is expected while the run is below DLY+1.
  logic [SYN-1:0] mSync;
  int mRun;
  logic mPrevExp;

  function automatic logic expInit(int run);
    return (run < DLY + 1);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSync <= '1;
      mRun  <= 0;
    end else begin
      mSync <= {mSync[SYN-2:0], dcLow};
      mRun  <= mSync[SYN-1] ? 0 : ((mRun > DLY + 5) ? mRun : mRun + 1);
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // cycle monitor
  always @(negedge clk) begin
    cycles++;
    if (rstN && monOn) begin
      logic e;
      e = expInit(mRun);
      if (mPrevExp && !e)      check("R4", procInit, e);
      else if (!mPrevExp && e) check("R5", procInit, e);
      else                     check("R8", procInit, e);
      check("R2", procClkEn, ~procInit);
      mPrevExp = e;
    end else begin
      mPrevExp = 1'b1;
    end
  end

  task automatic edgesUntil(input logic target, output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (procInit !== target && n < 200);
  endtask

  initial begin
    int n;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1: during reset
    check("R1", procInit, 1'b1);
    check("R1", procClkEn, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", procInit, 1'b1);
    check("R1", procClkEn, 1'b0);
    monOn = 1'b1;

    // R8: long supply-bad phase
    repeat (3 * DLY) @(negedge clk);
    check("R8", procInit, 1'b1);

    // R4: exact release edge count
    dcLow = 1'b0;
    edgesUntil(1'b0, n);
    checks++;
    if (n != RELEASE_EDGES) begin
      fails++;
      $display("FAIL R4: release after %0d edges expected %0d", n, RELEASE_EDGES);
    end

    // R7: AC-low while running
    for (int i = 0; i < 12; i++) begin
      acLow = ~acLow;
      @(negedge clk);
      check("R7", procInit, 1'b0);
    end
    acLow = 1'b0;

    // R5 / R3: reassert latency through the synchronizer
    dcLow = 1'b1;
    edgesUntil(1'b1, n);
    checks++;
    if (n != REASSERT_EDGES) begin
      fails++;
      $display("FAIL R3: reassert after %0d edges expected %0d", n, REASSERT_EDGES);
    end

    // R7: AC-low held low does not release while supply bad
    repeat (DLY + 10) @(negedge clk);
    check("R7", procInit, 1'b1);

    // R6: one-cycle glitch in the middle of the hold-off
    dcLow = 1'b0;
    repeat (10) @(negedge clk);
    dcLow = 1'b1;
    @(negedge clk);
    dcLow = 1'b0;
    edgesUntil(1'b0, n);
    checks++;
    if (n != RELEASE_EDGES) begin
      fails++;
      $display("FAIL R6: release after %0d edges expected %0d", n, RELEASE_EDGES);
    end

    // R6: glitch while running raises init
    dcLow = 1'b1;
    @(negedge clk);
    dcLow = 1'b0;
    repeat (SYN + 1) @(negedge clk);
    check("R6", procInit, 1'b1);
    repeat (DLY + 5) @(negedge clk);

    // random phases, many shorter than the hold-off
    for (int p = 0; p < 300; p++) begin
      int len;
      dcLow = ($urandom % 3) == 0;
      len = 1 + ($urandom % 40);
      for (int c = 0; c < len; c++) begin
        acLow = $urandom % 2;
        @(negedge clk);
      end
    end

    finish();
  end

  task automatic finish();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5ns * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

endmodule